// File: doc/BRIEF.md
# Two-Beat Synchronous SRAM Access Controller

This controller lets a CPU with a 36-bit data word use a pipelined synchronous SRAM with an 18-bit data bus. The SRAM clock runs four times faster than the CPU clock, and the two clocks are phase-aligned. Each CPU read or write becomes one fixed burst of two memory beats. The burst fills exactly four memory-clock cycles, so the CPU sees a memory that keeps pace with it. The low SRAM address bit selects the beat. The CPU word address fills the SRAM address bits above it. The SRAM's internal burst counter is never used: the advance/load pin stays at its load level, and every beat carries an explicit address.

The whole block runs on the memory clock. A CPU clock edge falls on the first memory edge after reset release and on every fourth memory edge after that. A request is sampled only on those boundary edges. The state machine has five states:
- `ST_IDLE`: no access.
- `ST_ADDR_HI` and `ST_ADDR_LO`: chip enable active, beat addresses issued.
- `ST_DATA_HI` and `ST_DATA_LO`: write data driven, or read data captured, two cycles after the matching address.

The transitions are:
- *start*: `ST_IDLE` to `ST_ADDR_HI`, taken on a boundary edge while a request is present.
- *step*: `ST_ADDR_HI` to `ST_ADDR_LO` to `ST_DATA_HI` to `ST_DATA_LO`, unconditional.
- *chain*: `ST_DATA_LO` to `ST_ADDR_HI`, taken when a request is present at the boundary edge that ends an access.
- *finish*: `ST_DATA_LO` to `ST_IDLE`, taken otherwise.

The data bus is brought out as separate output, enable and input vectors. An external pad ring forms the tri-state bus from them.

Top module: `ssram_burst_ctrl`

## Requirements
- R1: While reset is asserted, and after it until a request is accepted, the controller holds `sram_ce_n`=1, `sram_we_n`=1, all `sram_bw_n` bits at 1, `sram_dq_oe`=0 and `cpu_ack`=0. `cpu_rdata` resets to 0. Asserting reset in the middle of an access returns these pins to the same levels at once.
- R2: `sram_adv` is 0 (load an explicit address) in every cycle.
- R3: An access makes `sram_ce_n` low for exactly two consecutive cycles, the first two after the accepting edge. The first cycle drives `sram_addr` = {cpu_addr, 1'b0} and the second drives {cpu_addr, 1'b1}.
- R4: On a write, `sram_we_n` and every `sram_bw_n` bit are low in both address cycles. `sram_dq_oe` is high only in the third and fourth cycles. `sram_dq_o` carries cpu_wdata[35:18] in the third cycle and cpu_wdata[17:0] in the fourth.
- R5: On a read, `sram_we_n` is high and `sram_dq_oe` stays low. `sram_dq_i` is sampled at the end of the third cycle as bits [35:18] and at the end of the fourth cycle as bits [17:0]. Both halves appear together on `cpu_rdata`.
- R6: `cpu_ack` rises on the boundary edge that ends the access and stays high for exactly four memory cycles, unless a chained access extends it.
- R7: A request present between boundary edges is not acted on until the next boundary edge. `sram_ce_n` stays high until then.
- R8: A request present at the boundary edge that ends an access starts the next access at once. `sram_ce_n` is low in the very next cycle.
- R9: A write leaves `cpu_rdata` unchanged from the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_clk | input | 1 | Memory clock, four times the CPU clock, phase-aligned |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, sampled on boundary edges |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU word address |
| cpu_wdata | input | WORD_W | Write word |
| cpu_ack | output | 1 | Completion, one CPU period wide |
| cpu_rdata | output | WORD_W | Read word |
| sram_addr | output | ADDR_W+1 | SRAM address, bit 0 selects the beat |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_adv | output | 1 | Advance/load control, held at load (0) |
| sram_bw_n | output | WORD_W/2/LANE_W | Byte-lane write enables, active low |
| sram_dq_o | output | WORD_W/2 | Data toward the SRAM |
| sram_dq_oe | output | 1 | Output enable for sram_dq_o |
| sram_dq_i | input | WORD_W/2 | Data from the SRAM |

## Verification
A wrong state register appears at the SRAM pins within one memory cycle. Chip enable is held for the wrong number of cycles, the beat bit is wrong, or the drivers turn on during an address cycle. A wrong capture or a wrong half order stays hidden until `cpu_ack` rises one CPU period after the request. Only a comparison of read data against earlier writes exposes it. The SRAM model in the bench therefore checks the pin sequence of every beat, and it also checks full round trips that use distinct upper and lower halves.

// File: rtl/ssram_ctrl_pkg.sv
package ssram_ctrl_pkg;

    // memory clocks per CPU clock; the burst sequence is built for four
    localparam int unsigned MEM_PER_CPU = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA_HI,
        ST_DATA_LO
    } burst_state_e;

endpackage

// File: rtl/ssram_phase_gen.sv
module ssram_phase_gen
    import ssram_ctrl_pkg::*;
(
    input  logic mem_clk,
    input  logic rst_n,
    output logic cpu_edge
);
    localparam int unsigned PW = $clog2(MEM_PER_CPU);

    logic [PW-1:0] phase_q;

    always_ff @(posedge mem_clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // the edge taken while phase is zero coincides with a CPU clock edge
    assign cpu_edge = (phase_q == '0);
endmodule

// File: rtl/ssram_req_latch.sv
module ssram_req_latch #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned WORD_W = 36
) (
    input  logic              mem_clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              lat_we,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [WORD_W-1:0] lat_wdata
);
    always_ff @(posedge mem_clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_we    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_we    <= cpu_we;
            lat_addr  <= cpu_addr;
            lat_wdata <= cpu_wdata;
        end
    end
endmodule

// File: rtl/ssram_burst_fsm.sv
module ssram_burst_fsm
    import ssram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned WORD_W = 36,
    parameter int unsigned LANE_W = 9
) (
    input  logic                       mem_clk,
    input  logic                       rst_n,
    input  logic                       cpu_edge,
    input  logic                       cpu_req,
    input  logic                       lat_we,
    input  logic [ADDR_W-1:0]          lat_addr,
    input  logic [WORD_W-1:0]          lat_wdata,
    output logic                       accept,
    output burst_state_e               state,
    output logic [ADDR_W:0]            sram_addr,
    output logic                       sram_ce_n,
    output logic                       sram_we_n,
    output logic [WORD_W/2/LANE_W-1:0] sram_bw_n,
    output logic [WORD_W/2-1:0]        sram_dq_o,
    output logic                       sram_dq_oe
);
    localparam int unsigned BEAT_W = WORD_W / 2;
    localparam int unsigned LANES  = BEAT_W / LANE_W;

    burst_state_e state_q, state_d;

    assign accept = cpu_edge && cpu_req &&
                    ((state_q == ST_IDLE) || (state_q == ST_DATA_LO));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = accept ? ST_ADDR_HI : ST_IDLE;
            ST_ADDR_HI: state_d = ST_ADDR_LO;
            ST_ADDR_LO: state_d = ST_DATA_HI;
            ST_DATA_HI: state_d = ST_DATA_LO;
            ST_DATA_LO: state_d = accept ? ST_ADDR_HI : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge mem_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // pin decode
    always_comb begin
        sram_ce_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_bw_n  = '1;
        sram_addr  = {lat_addr, 1'b0};
        sram_dq_o  = '0;
        sram_dq_oe = 1'b0;
        unique case (state_q)
            ST_ADDR_HI: begin
                sram_ce_n = 1'b0;
                sram_we_n = ~lat_we;
                sram_bw_n = {LANES{~lat_we}};
                sram_addr = {lat_addr, 1'b0};
            end
            ST_ADDR_LO: begin
                sram_ce_n = 1'b0;
                sram_we_n = ~lat_we;
                sram_bw_n = {LANES{~lat_we}};
                sram_addr = {lat_addr, 1'b1};
            end
            ST_DATA_HI: begin
                sram_dq_oe = lat_we;
                sram_dq_o  = lat_wdata[WORD_W-1:BEAT_W];
            end
            ST_DATA_LO: begin
                sram_dq_oe = lat_we;
                sram_dq_o  = lat_wdata[BEAT_W-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ssram_rd_join.sv
module ssram_rd_join
    import ssram_ctrl_pkg::*;
#(
    parameter int unsigned WORD_W = 36
) (
    input  logic                mem_clk,
    input  logic                rst_n,
    input  logic                cpu_edge,
    input  burst_state_e        state,
    input  logic                lat_we,
    input  logic [WORD_W/2-1:0] sram_dq_i,
    output logic                cpu_ack,
    output logic [WORD_W-1:0]   cpu_rdata
);
    localparam int unsigned BEAT_W = WORD_W / 2;

    logic [BEAT_W-1:0] hi_q;
    logic              ack_q;
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge mem_clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if ((state == ST_DATA_HI) && !lat_we) begin
                hi_q <= sram_dq_i;
            end
            if (state == ST_DATA_LO) begin
                ack_q <= 1'b1;
                if (!lat_we) begin
                    rdata_q <= {hi_q, sram_dq_i};
                end
            end else if (cpu_edge) begin
                ack_q <= 1'b0;
            end
        end
    end

    assign cpu_ack   = ack_q;
    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/ssram_burst_ctrl.sv
module ssram_burst_ctrl
    import ssram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned WORD_W = 36,
    parameter int unsigned LANE_W = 9
) (
    input  logic                       mem_clk,
    input  logic                       rst_n,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [WORD_W-1:0]          cpu_wdata,
    output logic                       cpu_ack,
    output logic [WORD_W-1:0]          cpu_rdata,
    output logic [ADDR_W:0]            sram_addr,
    output logic                       sram_ce_n,
    output logic                       sram_we_n,
    output logic                       sram_adv,
    output logic [WORD_W/2/LANE_W-1:0] sram_bw_n,
    output logic [WORD_W/2-1:0]        sram_dq_o,
    output logic                       sram_dq_oe,
    input  logic [WORD_W/2-1:0]        sram_dq_i
);
    logic              cpu_edge;
    logic              accept;
    logic              lat_we;
    logic [ADDR_W-1:0] lat_addr;
    logic [WORD_W-1:0] lat_wdata;
    burst_state_e      state;

    // every beat is loaded with an explicit address
    assign sram_adv = 1'b0;

    ssram_phase_gen u_phase (
        .mem_clk  (mem_clk),
        .rst_n    (rst_n),
        .cpu_edge (cpu_edge)
    );

    ssram_req_latch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_latch (
        .mem_clk   (mem_clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .lat_we    (lat_we),
        .lat_addr  (lat_addr),
        .lat_wdata (lat_wdata)
    );

    ssram_burst_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_fsm (
        .mem_clk    (mem_clk),
        .rst_n      (rst_n),
        .cpu_edge   (cpu_edge),
        .cpu_req    (cpu_req),
        .lat_we     (lat_we),
        .lat_addr   (lat_addr),
        .lat_wdata  (lat_wdata),
        .accept     (accept),
        .state      (state),
        .sram_addr  (sram_addr),
        .sram_ce_n  (sram_ce_n),
        .sram_we_n  (sram_we_n),
        .sram_bw_n  (sram_bw_n),
        .sram_dq_o  (sram_dq_o),
        .sram_dq_oe (sram_dq_oe)
    );

    ssram_rd_join #(.WORD_W(WORD_W)) u_join (
        .mem_clk   (mem_clk),
        .rst_n     (rst_n),
        .cpu_edge  (cpu_edge),
        .state     (state),
        .lat_we    (lat_we),
        .sram_dq_i (sram_dq_i),
        .cpu_ack   (cpu_ack),
        .cpu_rdata (cpu_rdata)
    );
endmodule

// File: rtl/ssram_burst_ctrl_chk.sv
module ssram_burst_ctrl_chk #(
    parameter int unsigned ADDR_W = 20
) (
    input logic          mem_clk,
    input logic          rst_n,
    input logic [ADDR_W:0] sram_addr,
    input logic          sram_ce_n,
    input logic          sram_we_n,
    input logic          sram_dq_oe
);
    // R3
    beat0_addr_chk: assert property (@(posedge mem_clk) disable iff (!rst_n)
        $fell(sram_ce_n) |-> (sram_addr[0] == 1'b0));

    // R3
    beat1_addr_chk: assert property (@(posedge mem_clk) disable iff (!rst_n)
        $fell(sram_ce_n) |=> (!sram_ce_n && sram_addr[0] &&
                              (sram_addr[ADDR_W:1] == $past(sram_addr[ADDR_W:1]))));

    // R3
    ce_two_cycles_chk: assert property (@(posedge mem_clk) disable iff (!rst_n)
        (!sram_ce_n && !$past(sram_ce_n)) |=> sram_ce_n);

    // R4
    no_drive_on_addr_chk: assert property (@(posedge mem_clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_ce_n);

    // R4
    drive_after_write_chk: assert property (@(posedge mem_clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> ($past(sram_we_n, 2) == 1'b0));

    // R1
    we_needs_ce_chk: assert property (@(posedge mem_clk) disable iff (!rst_n)
        sram_ce_n |-> sram_we_n);
endmodule

bind ssram_burst_ctrl ssram_burst_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .mem_clk    (mem_clk),
    .rst_n      (rst_n),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/ssram_burst_ctrl_bench.sv
`timescale 1ns/1ps
module ssram_burst_ctrl_bench;
    localparam int AW = 20;
    localparam int WW = 36;
    localparam int BW = 18;

    logic          mem_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we  = 1'b0;
    logic [AW-1:0] cpu_addr  = '0;
    logic [WW-1:0] cpu_wdata = '0;
    logic          cpu_ack;
    logic [WW-1:0] cpu_rdata;
    logic [AW:0]   sram_addr;
    logic          sram_ce_n, sram_we_n, sram_adv, sram_dq_oe;
    logic [1:0]    sram_bw_n;
    logic [BW-1:0] sram_dq_o, sram_dq_i;

    int n_chk  = 0;
    int n_fail = 0;
    logic [1:0]    bph;
    logic [WW-1:0] last_rd = '0;

    always #2.5 mem_clk = ~mem_clk;

    ssram_burst_ctrl u_ssram_burst_ctrl (
        .mem_clk(mem_clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_we_n(sram_we_n), .sram_adv(sram_adv), .sram_bw_n(sram_bw_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    // bench phase: the next posedge is a CPU edge when bph == 0
    always @(posedge mem_clk or negedge rst_n)
        if (!rst_n) bph <= 2'd0; else bph <= bph + 2'd1;

    // pipelined SRAM model, two-cycle data latency
    logic [BW-1:0] mem [0:63];
    logic       s1_v = 1'b0, s1_w = 1'b0, s2_v = 1'b0, s2_w = 1'b0;
    logic [5:0] s1_a = '0, s2_a = '0;
    always @(posedge mem_clk) begin
        s1_v <= !sram_ce_n; s1_w <= !sram_we_n; s1_a <= sram_addr[5:0];
        s2_v <= s1_v;       s2_w <= s1_w;       s2_a <= s1_a;
        if (s2_v && s2_w) mem[s2_a] <= sram_dq_o;
    end
    assign sram_dq_i = (s2_v && !s2_w) ? mem[s2_a] : '0;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic to_boundary();
        @(negedge mem_clk);
        while (bph != 2'd0) @(negedge mem_clk);
    endtask

    // one complete access with pin checks; d is write data or expected read data
    task automatic run_access(input logic we, input logic [AW-1:0] a, input logic [WW-1:0] d);
        to_boundary();
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = we ? d : 36'h0;
        @(negedge mem_clk);
        cpu_req = 1'b0;
        chk(sram_ce_n == 1'b0, "R3 ce beat0", 64'(sram_ce_n), 64'(0));
        chk(sram_addr == {a, 1'b0}, "R3 addr beat0", 64'(sram_addr), 64'({a, 1'b0}));
        chk(sram_adv == 1'b0, "R2 adv", 64'(sram_adv), 64'(0));
        chk(sram_we_n == !we, "R4/R5 we_n beat0", 64'(sram_we_n), 64'(!we));
        chk(sram_bw_n == {2{!we}}, "R4 bw_n beat0", 64'(sram_bw_n), 64'({2{!we}}));
        chk(sram_dq_oe == 1'b0, "R4 oe addr", 64'(sram_dq_oe), 64'(0));
        @(negedge mem_clk);
        chk(sram_ce_n == 1'b0, "R3 ce beat1", 64'(sram_ce_n), 64'(0));
        chk(sram_addr == {a, 1'b1}, "R3 addr beat1", 64'(sram_addr), 64'({a, 1'b1}));
        chk(sram_we_n == !we, "R4/R5 we_n beat1", 64'(sram_we_n), 64'(!we));
        @(negedge mem_clk);
        chk(sram_ce_n == 1'b1, "R3 ce off", 64'(sram_ce_n), 64'(1));
        chk(sram_dq_oe == we, "R4/R5 oe data0", 64'(sram_dq_oe), 64'(we));
        if (we) chk(sram_dq_o == d[35:18], "R4 data hi", 64'(sram_dq_o), 64'(d[35:18]));
        @(negedge mem_clk);
        chk(sram_dq_oe == we, "R4/R5 oe data1", 64'(sram_dq_oe), 64'(we));
        if (we) chk(sram_dq_o == d[17:0], "R4 data lo", 64'(sram_dq_o), 64'(d[17:0]));
        chk(cpu_ack == 1'b0, "R6 ack not early", 64'(cpu_ack), 64'(0));
        @(negedge mem_clk);
        chk(cpu_ack == 1'b1, "R6 ack", 64'(cpu_ack), 64'(1));
        chk(sram_ce_n && sram_we_n && !sram_dq_oe, "R1 idle pins", 64'({sram_ce_n, sram_we_n, sram_dq_oe}), 64'(3'b110));
        if (we) begin
            chk(cpu_rdata == last_rd, "R9 rdata kept", 64'(cpu_rdata), 64'(last_rd));
        end else begin
            chk(cpu_rdata == d, "R5 rdata", 64'(cpu_rdata), 64'(d));
            last_rd = d;
        end
        repeat (3) @(negedge mem_clk);
        chk(cpu_ack == 1'b1, "R6 ack held", 64'(cpu_ack), 64'(1));
        @(negedge mem_clk);
        chk(cpu_ack == 1'b0, "R6 ack width", 64'(cpu_ack), 64'(0));
    endtask

    // {we, addr, data}: write data, or expected read data
    localparam logic [56:0] VEC [8] = '{
        {1'b1, 20'h00000, 36'h123456789},
        {1'b1, 20'h00001, 36'hFEDCBA987},
        {1'b1, 20'hABC1F, 36'h800000001},
        {1'b1, 20'h5550A, 36'h3FFFC0000},
        {1'b0, 20'h00001, 36'hFEDCBA987},
        {1'b0, 20'h00000, 36'h123456789},
        {1'b0, 20'h5550A, 36'h3FFFC0000},
        {1'b0, 20'hABC1F, 36'h800000001}
    };

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge mem_clk);
        // R1 reset state
        chk(sram_ce_n == 1'b1, "R1 ce_n", 64'(sram_ce_n), 64'(1));
        chk(sram_we_n == 1'b1, "R1 we_n", 64'(sram_we_n), 64'(1));
        chk(sram_bw_n == 2'b11, "R1 bw_n", 64'(sram_bw_n), 64'(3));
        chk(sram_dq_oe == 1'b0, "R1 oe", 64'(sram_dq_oe), 64'(0));
        chk(cpu_ack == 1'b0, "R1 ack", 64'(cpu_ack), 64'(0));
        chk(cpu_rdata == '0, "R1 rdata", 64'(cpu_rdata), 64'(0));
        chk(sram_adv == 1'b0, "R2 adv reset", 64'(sram_adv), 64'(0));
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            run_access(VEC[i][56], VEC[i][55:36], VEC[i][35:0]);
        end

        // R8 chained access: write then read issued at the ending boundary
        to_boundary();
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 20'h00000; cpu_wdata = 36'h0F0F0F0F0;
        @(negedge mem_clk);
        cpu_req = 1'b0;
        repeat (3) @(negedge mem_clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 20'h00000; cpu_wdata = '0;
        @(negedge mem_clk);
        cpu_req = 1'b0;
        chk(sram_ce_n == 1'b0, "R8 chained start", 64'(sram_ce_n), 64'(0));
        chk(sram_addr == 21'h0, "R8 chained addr", 64'(sram_addr), 64'(0));
        chk(cpu_ack == 1'b1, "R6 ack write in chain", 64'(cpu_ack), 64'(1));
        repeat (4) @(negedge mem_clk);
        chk(cpu_ack == 1'b1, "R6 ack chained read", 64'(cpu_ack), 64'(1));
        chk(cpu_rdata == 36'h0F0F0F0F0, "R8 chained rdata", 64'(cpu_rdata), 64'(36'h0F0F0F0F0));
        last_rd = 36'h0F0F0F0F0;

        // R7 request raised between boundaries waits for the next one
        repeat (8) @(negedge mem_clk);
        while (bph != 2'd2) @(negedge mem_clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 20'h00001;
        @(negedge mem_clk);
        chk(sram_ce_n == 1'b1, "R7 held 1", 64'(sram_ce_n), 64'(1));
        @(negedge mem_clk);
        chk(sram_ce_n == 1'b1, "R7 held 2", 64'(sram_ce_n), 64'(1));
        @(negedge mem_clk);
        cpu_req = 1'b0;
        chk(sram_ce_n == 1'b0, "R7 started", 64'(sram_ce_n), 64'(0));
        chk(sram_addr == {20'h00001, 1'b0}, "R7 addr", 64'(sram_addr), 64'({20'h00001, 1'b0}));
        repeat (4) @(negedge mem_clk);
        chk(cpu_rdata == 36'hFEDCBA987, "R7 rdata", 64'(cpu_rdata), 64'(36'hFEDCBA987));

        // R1 reset in the middle of a write
        to_boundary();
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 20'h00002; cpu_wdata = 36'h111111111;
        @(negedge mem_clk);
        cpu_req = 1'b0;
        @(negedge mem_clk);
        rst_n = 1'b0;
        #1;
        chk(sram_ce_n == 1'b1, "R1 mid reset ce_n", 64'(sram_ce_n), 64'(1));
        chk(sram_we_n == 1'b1, "R1 mid reset we_n", 64'(sram_we_n), 64'(1));
        @(negedge mem_clk);
        chk(sram_dq_oe == 1'b0, "R1 mid reset oe", 64'(sram_dq_oe), 64'(0));
        chk(cpu_ack == 1'b0, "R1 mid reset ack", 64'(cpu_ack), 64'(0));
        rst_n = 1'b1;
        last_rd = '0;
        run_access(1'b0, 20'hABC1F, 36'h800000001);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge mem_clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule